// File: doc/BRIEF.md
# JTAG master shift engine

This block drives a JTAG chain from a host-programmed configuration. Each session shifts a programmed number of bits onto TDI and TMS. Every bit comes from one entry of an external transmit FIFO. The block generates TCK by dividing the system clock. On each rising TCK edge it samples TDO, or its own TDI bit when loopback is on, and pushes the result to an external receive FIFO.

A session opens on a start strobe. It closes at the first bit boundary where one of three things holds: a stop request is pending, the programmed count is complete, or the transmit FIFO has nothing to offer. One of three sticky flags records which of these ended it. When the reset-enable bit is set at start, the first FIFO entry is consumed and TRST is held low for eight TCK periods in place of shifting. Two gating controls keep the chain quiet while the engine runs internally: port disable and loopback.

Top module: `jtag_shift_master`

## Requirements
- R1: When `start` is seen while idle, `session_busy` is high and all three flags are low in the next cycle. A `start` during a running session changes nothing about that session.
- R2: A session shifts `cfg_size + 1` bits, so a size of 0 shifts one bit. Each bit consumes one TX entry. The session then ends with `done_flag` set, and any further TX entries are left in the FIFO.
- R3: If the TX FIFO has fewer entries than the count needs, every valid entry is shifted. The session then ends at the next bit boundary with `underrun_flag` set.
- R4: A `stop` pulse during a session lets the current bit finish and ends the session at the next bit boundary, setting `abort_flag`. A stop seen at a boundary cycle prevents that boundary's pop.
- R5: One TCK period spans max(`cfg_ratio`, 4) system clocks. TCK is low for floor(period/2) of them and high for the remainder.
- R6: Each bit's TDI and TMS values appear on the pins while TCK is low. The TDO level sampled at the TCK rise is delivered on `rx_data` with a one-cycle `rx_valid` pulse.
- R7: With `cfg_loopback` = 1, each pushed RX bit equals the TDI bit of the same entry, and TCK, TDI and TMS stay low at the pins.
- R8: With `cfg_port_en` = 0, TCK, TDI and TMS stay low at the pins. Pops, RX pushes and flags are the same as in normal operation.
- R9: `jtag_en` follows `cfg_host_en` and has no effect on sequencing.
- R10: With `cfg_trst_en` = 1 at start, one TX entry is consumed and `jtag_trst_n` is low for exactly 8 TCK periods. No RX data is produced, and the session ends with `done_flag`. If the FIFO is empty, no reset occurs and the session ends with `underrun_flag`.
- R11: At most one flag is set at any time. Exactly one flag is set when a session ends, and it holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size | input | 16 | Bits per session minus one |
| cfg_ratio | input | 8 | TCK divide ratio in system clocks, values below 4 act as 4 |
| cfg_trst_en | input | 1 | Session issues a TRST pulse instead of shifting |
| cfg_loopback | input | 1 | Feed TDI back to RX and gate the pins |
| cfg_port_en | input | 1 | Allow TCK/TDI/TMS onto the pins |
| cfg_host_en | input | 1 | Level for the chain enable output |
| start | input | 1 | Session start strobe |
| stop | input | 1 | Session stop strobe |
| tx_valid | input | 1 | TX FIFO has an entry |
| tx_tdi | input | 1 | TDI bit of the head entry |
| tx_tms | input | 1 | TMS bit of the head entry |
| tx_ready | output | 1 | Engine takes the head entry this cycle |
| rx_valid | output | 1 | RX push strobe |
| rx_data | output | 1 | Captured bit |
| session_busy | output | 1 | Session in progress |
| done_flag | output | 1 | Last session completed its count |
| underrun_flag | output | 1 | Last session ran out of TX data |
| abort_flag | output | 1 | Last session was stopped |
| jtag_tck | output | 1 | Test clock pin |
| jtag_tdi | output | 1 | Test data out to the chain |
| jtag_tms | output | 1 | Test mode select pin |
| jtag_trst_n | output | 1 | Active-low test reset pin |
| jtag_en | output | 1 | Chain enable output |
| jtag_tdo | input | 1 | Test data from the chain |

## Verification
The bench builds the block with its default parameters: a 16-bit size field, an 8-bit ratio field and an 8-period reset pulse. It sweeps sizes 0 to 4 against FIFO fills that run short, match the count exactly, or leave entries over. Ratios 2, 4, 5 and 7 are covered, so the clamp below 4 and both odd and even low/high splits are exercised. Each case runs in normal, loopback and port-disabled modes. A one-bit-delay chain model on the pins makes every captured bit depend on the bit shifted before it. Stops land exactly on a bit boundary and one cycle after it, and reset pulses are run at two ratios and with an empty FIFO.

// File: rtl/jtag_shift_master.sv
module jtag_shift_master #(
  parameter int SIZE_W    = 16,
  parameter int RATIO_W   = 8,
  parameter int MIN_RATIO = 4,
  parameter int TRST_TCKS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SIZE_W-1:0]  cfg_size,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic               cfg_trst_en,
  input  logic               cfg_loopback,
  input  logic               cfg_port_en,
  input  logic               cfg_host_en,
  input  logic               start,
  input  logic               stop,
  input  logic               tx_valid,
  input  logic               tx_tdi,
  input  logic               tx_tms,
  output logic               tx_ready,
  output logic               rx_valid,
  output logic               rx_data,
  output logic               session_busy,
  output logic               done_flag,
  output logic               underrun_flag,
  output logic               abort_flag,
  output logic               jtag_tck,
  output logic               jtag_tdi,
  output logic               jtag_tms,
  output logic               jtag_trst_n,
  output logic               jtag_en,
  input  logic               jtag_tdo
);
  localparam int CNT_W = SIZE_W + 1;

  logic               busy_q, trst_mode_q, stop_pend_q;
  logic [RATIO_W-1:0] ratio_q, ph_q;
  logic [SIZE_W-1:0]  size_q;
  logic [CNT_W-1:0]   nbits_q;
  logic               tck_q, tdi_q, tms_q, trst_q;
  logic               rx_v_q, rx_d_q;
  logic               done_q, unr_q, abt_q;

  wire [RATIO_W-1:0] ratio_eff = (cfg_ratio < RATIO_W'(MIN_RATIO)) ? RATIO_W'(MIN_RATIO) : cfg_ratio;
  wire [RATIO_W-1:0] lo_len    = ratio_q >> 1;
  wire [CNT_W-1:0]   term      = trst_mode_q ? CNT_W'(TRST_TCKS) : {1'b0, size_q} + CNT_W'(1);

  wire boundary   = busy_q && (ph_q == '0);
  wire stop_any   = stop || stop_pend_q;
  wire count_done = (nbits_q == term);
  wire need_data  = !trst_mode_q || (nbits_q == '0);
  wire pop        = tx_ready && tx_valid;
  wire advance    = boundary && !stop_any && !count_done && (pop || !need_data);
  wire finish     = boundary && !advance;
  wire pins_on    = cfg_port_en && !cfg_loopback;

  assign tx_ready = boundary && !stop_any && !count_done && need_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      trst_mode_q <= 1'b0;
      stop_pend_q <= 1'b0;
      ratio_q     <= RATIO_W'(MIN_RATIO);
      ph_q        <= '0;
      size_q      <= '0;
      nbits_q     <= '0;
      tck_q       <= 1'b0;
      tdi_q       <= 1'b0;
      tms_q       <= 1'b0;
      trst_q      <= 1'b0;
      rx_v_q      <= 1'b0;
      rx_d_q      <= 1'b0;
      done_q      <= 1'b0;
      unr_q       <= 1'b0;
      abt_q       <= 1'b0;
    end else begin
      rx_v_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q      <= 1'b1;
          ratio_q     <= ratio_eff;
          size_q      <= cfg_size;
          trst_mode_q <= cfg_trst_en;
          ph_q        <= '0;
          nbits_q     <= '0;
          stop_pend_q <= 1'b0;
          done_q      <= 1'b0;
          unr_q       <= 1'b0;
          abt_q       <= 1'b0;
        end
      end else begin
        if (stop) stop_pend_q <= 1'b1;
        if (finish) begin
          busy_q <= 1'b0;
          tck_q  <= 1'b0;
          tdi_q  <= 1'b0;
          tms_q  <= 1'b0;
          trst_q <= 1'b0;
          abt_q  <= stop_any;
          done_q <= !stop_any && count_done;
          unr_q  <= !stop_any && !count_done;
        end else if (advance) begin
          ph_q    <= RATIO_W'(1);
          tck_q   <= 1'b0;
          nbits_q <= nbits_q + CNT_W'(1);
          if (trst_mode_q) begin
            trst_q <= 1'b1;
          end else begin
            tdi_q <= tx_tdi;
            tms_q <= tx_tms;
          end
        end else begin
          if (ph_q == lo_len) begin
            tck_q <= 1'b1;
            if (!trst_mode_q) begin
              rx_v_q <= 1'b1;
              rx_d_q <= cfg_loopback ? tdi_q : jtag_tdo;
            end
          end
          ph_q <= (ph_q == ratio_q - RATIO_W'(1)) ? '0 : ph_q + RATIO_W'(1);
        end
      end
    end
  end

  assign session_busy  = busy_q;
  assign done_flag     = done_q;
  assign underrun_flag = unr_q;
  assign abort_flag    = abt_q;
  assign rx_valid      = rx_v_q;
  assign rx_data       = rx_d_q;
  assign jtag_tck      = tck_q && pins_on;
  assign jtag_tdi      = tdi_q && pins_on;
  assign jtag_tms      = tms_q && pins_on;
  assign jtag_trst_n   = !trst_q;
  assign jtag_en       = cfg_host_en;
endmodule

// File: rtl/jtag_shift_master_chk.sv
module jtag_shift_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic session_busy,
  input logic done_flag,
  input logic underrun_flag,
  input logic abort_flag,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic jtag_tck,
  input logic jtag_trst_n,
  input logic cfg_port_en,
  input logic cfg_loopback
);
  // R11
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_flag, underrun_flag, abort_flag}));

  // R11
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(session_busy) |-> $countones({done_flag, underrun_flag, abort_flag}) == 1);

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!session_busy && !start) |=> $stable({done_flag, underrun_flag, abort_flag}));

  // R1
  start_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !session_busy) |=> (session_busy && !done_flag && !underrun_flag && !abort_flag));

  // R2
  pop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |-> session_busy);

  // R10
  trst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !jtag_trst_n |-> session_busy);

  // R10
  trst_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> jtag_trst_n);

  // R8
  tck_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jtag_tck) |-> (cfg_port_en && !cfg_loopback));
endmodule

bind jtag_shift_master jtag_shift_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .session_busy(session_busy),
  .done_flag(done_flag), .underrun_flag(underrun_flag), .abort_flag(abort_flag),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .jtag_tck(jtag_tck), .jtag_trst_n(jtag_trst_n),
  .cfg_port_en(cfg_port_en), .cfg_loopback(cfg_loopback)
);

// File: tb/jtag_shift_master_tb_top.sv
module jtag_shift_master_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cfg_size = '0;
  logic [7:0]  cfg_ratio = 8'd4;
  logic cfg_trst_en = 0, cfg_loopback = 0, cfg_port_en = 1, cfg_host_en = 0;
  logic start = 0, stop = 0;
  logic tx_valid, tx_tdi, tx_tms, tx_ready, rx_valid, rx_data;
  logic session_busy, done_flag, underrun_flag, abort_flag;
  logic jtag_tck, jtag_tdi, jtag_tms, jtag_trst_n, jtag_en, jtag_tdo;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_shift_master dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_ratio(cfg_ratio),
    .cfg_trst_en(cfg_trst_en), .cfg_loopback(cfg_loopback), .cfg_port_en(cfg_port_en),
    .cfg_host_en(cfg_host_en), .start(start), .stop(stop),
    .tx_valid(tx_valid), .tx_tdi(tx_tdi), .tx_tms(tx_tms), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .session_busy(session_busy),
    .done_flag(done_flag), .underrun_flag(underrun_flag), .abort_flag(abort_flag),
    .jtag_tck(jtag_tck), .jtag_tdi(jtag_tdi), .jtag_tms(jtag_tms),
    .jtag_trst_n(jtag_trst_n), .jtag_en(jtag_en), .jtag_tdo(jtag_tdo)
  );

  // bench-side FIFOs and chain model
  logic mem_tdi [0:63];
  logic mem_tms [0:63];
  logic rx_mem  [0:63];
  int   tx_cnt = 0, rd_ptr = 0, rx_n = 0;
  logic fifo_clr = 0, mon_clr = 0, chk_pins = 1, tap_init = 0, tap_q = 0;
  int   exp_r = 4, exp_lo = 2;
  int   cyc = 0, last_rise = -1, last_fall = -1, pk = 0;
  int   per_err = 0, lo_err = 0, pin_err = 0, gate_err = 0, trst_lo = 0;
  logic tck_prev = 0, pins_on_exp = 1;

  assign tx_valid = rd_ptr < tx_cnt;
  assign tx_tdi   = mem_tdi[rd_ptr[5:0]];
  assign tx_tms   = mem_tms[rd_ptr[5:0]];
  assign jtag_tdo = tap_q;

  always @(posedge clk) begin
    if (fifo_clr) begin
      rd_ptr <= 0;
      rx_n   <= 0;
    end else begin
      if (tx_valid && tx_ready) rd_ptr <= rd_ptr + 1;
      if (rx_valid) begin
        rx_mem[rx_n[5:0]] <= rx_data;
        rx_n <= rx_n + 1;
      end
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_clr) begin
      pk <= 0; tap_q <= tap_init; last_rise <= -1; last_fall <= -1;
      per_err <= 0; lo_err <= 0; pin_err <= 0; gate_err <= 0; trst_lo <= 0;
      tck_prev <= jtag_tck;
    end else begin
      if (jtag_tck && !tck_prev) begin
        if (last_rise >= 0 && cyc - last_rise != exp_r) per_err <= per_err + 1;
        if (last_fall >= 0 && cyc - last_fall != exp_lo) lo_err <= lo_err + 1;
        if (chk_pins && (jtag_tdi !== mem_tdi[pk[5:0]] || jtag_tms !== mem_tms[pk[5:0]]))
          pin_err <= pin_err + 1;
        pk <= pk + 1;
        tap_q <= jtag_tdi;
        last_rise <= cyc;
      end
      if (!jtag_tck && tck_prev) last_fall <= cyc;
      if (!pins_on_exp && (jtag_tck || jtag_tdi || jtag_tms)) gate_err <= gate_err + 1;
      if (!jtag_trst_n) trst_lo <= trst_lo + 1;
      tck_prev <= jtag_tck;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic open_session(input int avail, input int seed);
    for (int i = 0; i < 64; i++) begin
      mem_tdi[i] = (((i * 5 + seed) % 3) == 0);
      mem_tms[i] = (((i + seed) % 4) == 1);
    end
    tx_cnt = avail;
    tap_init = seed[0];
    tick();
    fifo_clr = 1; mon_clr = 1;
    tick();
    fifo_clr = 0; mon_clr = 0; start = 1;
    tick();
    start = 0;
    chk(session_busy === 1'b1 && {done_flag, underrun_flag, abort_flag} === 3'b000,
        "R1 open", {session_busy, done_flag, underrun_flag, abort_flag}, 8);
  endtask

  task automatic wait_end();
    for (int k = 0; k < 6000 && session_busy; k++) tick();
    tick();
  endtask

  // mode 0 normal, 1 loopback, 2 pins disabled
  task automatic run_shift(input int size, input int avail, input int ratio, input int mode, input int seed);
    int r, n;
    bit full;
    r = (ratio < 4) ? 4 : ratio;
    n = (size + 1 < avail) ? size + 1 : avail;
    full = (avail >= size + 1);
    cfg_size = 16'(size); cfg_ratio = 8'(ratio); cfg_trst_en = 0;
    cfg_loopback = (mode == 1); cfg_port_en = (mode != 2);
    pins_on_exp = (mode == 0); chk_pins = 1;
    exp_r = r; exp_lo = r / 2;
    open_session(avail, seed);
    wait_end();
    chk(rd_ptr == n, full ? "R2 pops" : "R3 pops", rd_ptr, n);
    chk(rx_n == n, mode == 2 ? "R8 rx count" : "R6 rx count", rx_n, n);
    chk({done_flag, underrun_flag, abort_flag} == (full ? 3'b100 : 3'b010),
        full ? "R2 done flag" : "R3 underrun flag",
        {done_flag, underrun_flag, abort_flag}, full ? 4 : 2);
    for (int i = 0; i < n; i++) begin
      logic e;
      if (mode == 1) e = mem_tdi[i];
      else if (mode == 2) e = tap_init;
      else e = (i == 0) ? tap_init : mem_tdi[i-1];
      chk(rx_mem[i] === e, mode == 1 ? "R7 loop data" : "R6 capture", rx_mem[i], e);
    end
    if (mode == 0) begin
      chk(pin_err == 0, "R6 pin data", pin_err, 0);
      chk(pk == n, "R6 tck rises", pk, n);
      chk(per_err == 0, "R5 period", per_err, 0);
      chk(lo_err == 0, "R5 low half", lo_err, 0);
    end else begin
      chk(gate_err == 0, mode == 1 ? "R7 pins low" : "R8 pins low", gate_err, 0);
    end
  endtask

  task automatic run_stop(input int stop_edge, input int exp_pops);
    cfg_size = 16'd20; cfg_ratio = 8'd4; cfg_trst_en = 0;
    cfg_loopback = 0; cfg_port_en = 1; pins_on_exp = 1; chk_pins = 1;
    exp_r = 4; exp_lo = 2;
    open_session(30, 3);
    repeat (2) tick();
    start = 1;
    tick();
    start = 0;
    repeat (stop_edge - 4) tick();
    stop = 1;
    tick();
    stop = 0;
    wait_end();
    chk(rd_ptr == exp_pops, "R4 pops at stop", rd_ptr, exp_pops);
    chk(rx_n == exp_pops, "R4 rx at stop", rx_n, exp_pops);
    chk({done_flag, underrun_flag, abort_flag} == 3'b001, "R4 abort flag",
        {done_flag, underrun_flag, abort_flag}, 1);
    chk(pin_err == 0, "R1 busy start ignored", pin_err, 0);
  endtask

  task automatic run_trst(input int ratio, input int avail);
    cfg_size = 16'd5; cfg_ratio = 8'(ratio); cfg_trst_en = 1;
    cfg_loopback = 0; cfg_port_en = 1; pins_on_exp = 1; chk_pins = 0;
    exp_r = ratio; exp_lo = ratio / 2;
    open_session(avail, 2);
    wait_end();
    chk(rd_ptr == (avail > 0 ? 1 : 0), "R10 pops", rd_ptr, avail > 0 ? 1 : 0);
    chk(rx_n == 0, "R10 no rx", rx_n, 0);
    chk(trst_lo == (avail > 0 ? 8 * ratio : 0), "R10 trst width", trst_lo, avail > 0 ? 8 * ratio : 0);
    chk({done_flag, underrun_flag, abort_flag} == (avail > 0 ? 3'b100 : 3'b010), "R10 flag",
        {done_flag, underrun_flag, abort_flag}, avail > 0 ? 4 : 2);
    chk(jtag_trst_n === 1'b1, "R10 released", jtag_trst_n, 1);
    cfg_trst_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int ratios[4] = '{2, 4, 5, 7};
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(session_busy === 0 && {done_flag, underrun_flag, abort_flag} === 3'b000,
        "R11 reset state", {session_busy, done_flag, underrun_flag, abort_flag}, 0);
    chk(jtag_tck === 0 && jtag_trst_n === 1 && tx_ready === 0 && rx_valid === 0,
        "R6 reset pins", {jtag_tck, jtag_trst_n, tx_ready, rx_valid}, 4);
    cfg_host_en = 1;
    tick();
    chk(jtag_en === 1, "R9 enable high", jtag_en, 1);
    for (int s = 0; s <= 4; s++)
      for (int a = 0; a < 3; a++)
        for (int m = 0; m < 3; m++) begin
          int av;
          av = (a == 0) ? s + 1 : (a == 1) ? s + 3 : s;
          run_shift(s, av, ratios[(s + a + m) % 4], m, s * 3 + a + m);
        end
    cfg_host_en = 0;
    tick();
    chk(jtag_en === 0, "R9 enable low", jtag_en, 0);
    run_shift(3, 4, 6, 0, 1);
    run_stop(9, 2);
    run_stop(10, 3);
    run_trst(4, 2);
    run_trst(6, 1);
    run_trst(4, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule